// File: doc/BRIEF.md
# Flying-Capacitor Five-Level Switch State Sequencer

This block drives the three switches of a single-phase five-level inverter built from one flying-capacitor leg and one ordinary two-level leg. A level-stepping controller upstream asks for an output level between -2 and +2 units. The sequencer keeps the present 3-bit switch pattern in flip-flops. On every clock it moves the output one level toward the request. It picks the next pattern from the present pattern, a capacitor-above-reference bit and a load-current-sign bit.

Two of the five levels, +1 and -1, can each be produced by two redundant patterns. One pattern charges the flying capacitor and the other discharges it. The sequencer takes the one that moves the capacitor voltage back toward its reference. Every transition changes a single switch, with four exceptions. Because of how the two legs are built, zero has two patterns. The step from all-off zero down to -1 and the step from all-on zero up to +1 each flip two switches, and these steps are only ever taken in that direction.

Top module: `flycap_state_seq`

## Requirements
- R1: While reset is asserted (asynchronous, active low), and after it is released with no step requested, the switch pattern is 000 and the reported level is 0.
- R2: Switch patterns (bit order {s2,s1,s0}) map to levels as follows: 110 is +2, 100 and 010 are +1, 000 and 111 are 0, 101 and 011 are -1, 001 is -2. The reported level is this mapping, as 3-bit two's complement, applied to the present pattern.
- R3: Each clock the level moves exactly one unit toward the requested level. When the two are equal, the switch pattern does not change.
- R4: The requested level is 3-bit two's complement. A request of +3 acts as +2, and requests of -3 or -4 act as -2.
- R5: On entering +1, the pattern is 100 when (current positive XOR capacitor above reference) was 1 in the stepping cycle, and 010 otherwise. That is, 100 is chosen for positive current with the capacitor low, or for negative current with it high.
- R6: On entering -1, the same rule picks 101 (rule value 1) or 011 (rule value 0).
- R7: The only transitions that change two switches are 000 to 101 or 011 (going down) and 111 to 100 or 010 (going up). Every other transition changes at most one switch.
- R8: Stepping down from +1 gives 000, and stepping up from -1 gives 111. The +2 level is 110 and the -2 level is 001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching-event clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| level_req | input | 3 | Requested output level, two's complement |
| cap_high | input | 1 | Flying capacitor is above its reference |
| cur_pos | input | 1 | Load current is positive |
| sw_state | output | 3 | Switch pattern {s2,s1,s0}, 1 = on |
| level_out | output | 3 | Level of the present pattern, two's complement |

## Verification
The bound checker checks the following on every cycle: the pattern changes a single switch except on the four allowed one-way pairs, the level moves by at most one unit and in the direction of the saturated request, the pattern holds once the request is met, the +1 and -1 redundant choice follows the balancing rule, and zero is entered through 000 from above and 111 from below. The bench's vector walk shows the things a single-cycle property cannot: the full tour through every pattern, out-of-range requests walking to the rail and stopping there, and the mirrored balancing choice for all four combinations of capacitor and current sign. A directed reset in the middle of the run shows that the pattern returns to 000 without waiting for a clock.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int SW_W  = 3;
  localparam int LVL_W = 3;

  typedef logic [SW_W-1:0]         sw_t;
  typedef logic signed [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_TOP = 3'sd2;
  localparam lvl_t LVL_BOT = -3'sd2;

  localparam sw_t SW_P2  = 3'b110;
  localparam sw_t SW_P1A = 3'b100;
  localparam sw_t SW_P1B = 3'b010;
  localparam sw_t SW_Z0  = 3'b000;
  localparam sw_t SW_Z1  = 3'b111;
  localparam sw_t SW_N1A = 3'b101;
  localparam sw_t SW_N1B = 3'b011;
  localparam sw_t SW_N2  = 3'b001;

  function automatic lvl_t sw_level(input sw_t s);
    case (s)
      SW_P2:          return 3'sd2;
      SW_P1A, SW_P1B: return 3'sd1;
      SW_N1A, SW_N1B: return -3'sd1;
      SW_N2:          return -3'sd2;
      default:        return 3'sd0;
    endcase
  endfunction

  function automatic lvl_t sat_level(input lvl_t r);
    if (r > LVL_TOP) return LVL_TOP;
    if (r < LVL_BOT) return LVL_BOT;
    return r;
  endfunction

  // 1: charging-side pattern of the redundant pair (100 / 101)
  function automatic logic pick_first(input logic cap_hi, input logic pos);
    return cap_hi ^ pos;
  endfunction
endpackage

// File: rtl/fcs_req_sat.sv
module fcs_req_sat
  import fcs_pkg::*;
(
  input  lvl_t req,
  output lvl_t tgt
);
  assign tgt = sat_level(req);
endmodule

// File: rtl/fcs_level_dec.sv
module fcs_level_dec
  import fcs_pkg::*;
(
  input  sw_t  sw,
  output lvl_t lvl
);
  assign lvl = sw_level(sw);
endmodule

// File: rtl/fcs_next_state.sv
module fcs_next_state
  import fcs_pkg::*;
(
  input  sw_t  cur,
  input  logic step_up,
  input  logic step_dn,
  input  logic pick_a,
  output sw_t  nxt
);
  always_comb begin
    nxt = cur;
    if (step_up) begin
      case (cur)
        SW_P1A, SW_P1B: nxt = SW_P2;
        SW_Z0, SW_Z1:   nxt = pick_a ? SW_P1A : SW_P1B;
        SW_N1A, SW_N1B: nxt = SW_Z1;
        SW_N2:          nxt = pick_a ? SW_N1A : SW_N1B;
        default:        nxt = cur;
      endcase
    end else if (step_dn) begin
      case (cur)
        SW_P2:          nxt = pick_a ? SW_P1A : SW_P1B;
        SW_P1A, SW_P1B: nxt = SW_Z0;
        SW_Z0, SW_Z1:   nxt = pick_a ? SW_N1A : SW_N1B;
        SW_N1A, SW_N1B: nxt = SW_N2;
        default:        nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/flycap_state_seq.sv
module flycap_state_seq
  import fcs_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [LVL_W-1:0] level_req,
  input  logic                    cap_high,
  input  logic                    cur_pos,
  output logic [SW_W-1:0]         sw_state,
  output logic signed [LVL_W-1:0] level_out
);
  lvl_t tgt_lvl;
  lvl_t lvl_now;
  sw_t  sw_q;
  sw_t  sw_nxt;
  logic step_up;
  logic step_dn;
  logic pick_a;

  fcs_req_sat u_sat (.req(level_req), .tgt(tgt_lvl));
  fcs_level_dec u_dec (.sw(sw_q), .lvl(lvl_now));

  assign step_up = (tgt_lvl > lvl_now);
  assign step_dn = (tgt_lvl < lvl_now);
  assign pick_a  = pick_first(cap_high, cur_pos);

  fcs_next_state u_nxt (
    .cur(sw_q), .step_up(step_up), .step_dn(step_dn),
    .pick_a(pick_a), .nxt(sw_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= SW_Z0;
    else        sw_q <= sw_nxt;
  end

  assign sw_state  = sw_q;
  assign level_out = lvl_now;
endmodule

// File: rtl/flycap_state_seq_chk.sv
module flycap_state_seq_chk
  import fcs_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic signed [LVL_W-1:0] level_req,
  input logic                    cap_high,
  input logic                    cur_pos,
  input logic [SW_W-1:0]         sw_state,
  input logic signed [LVL_W-1:0] level_out
);
  logic signed [LVL_W-1:0] req_cl;
  always_comb begin
    req_cl = level_req;
    if (level_req == 3'sd3) req_cl = 3'sd2;
    else if (level_req == -3'sd3 || level_req == -3'sd4) req_cl = -3'sd2;
  end

  // R7
  adjacency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sw_state ^ $past(sw_state)) <= 1) ||
    ($past(sw_state) == 3'b000 && (sw_state == 3'b101 || sw_state == 3'b011)) ||
    ($past(sw_state) == 3'b111 && (sw_state == 3'b100 || sw_state == 3'b010)));

  // R3
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_out == $past(level_out)) || (level_out == $past(level_out) + 3'sd1) ||
    (level_out == $past(level_out) - 3'sd1));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_out == req_cl) |=> $stable(sw_state));

  // R4
  rise_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_out < req_cl) |=> (level_out == $past(level_out) + 3'sd1));

  // R4
  fall_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_out > req_cl) |=> (level_out == $past(level_out) - 3'sd1));

  // R5
  pos_bal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(level_out) != 3'sd1 && level_out == 3'sd1) |->
    (sw_state == (($past(cap_high) != $past(cur_pos)) ? 3'b100 : 3'b010)));

  // R6
  neg_bal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(level_out) != -3'sd1 && level_out == -3'sd1) |->
    (sw_state == (($past(cap_high) != $past(cur_pos)) ? 3'b101 : 3'b011)));

  // R8
  zero_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_out == 3'sd0 && $past(level_out) != 3'sd0) |->
    (sw_state == (($past(level_out) == 3'sd1) ? 3'b000 : 3'b111)));
endmodule

bind flycap_state_seq flycap_state_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .level_req(level_req), .cap_high(cap_high),
  .cur_pos(cur_pos), .sw_state(sw_state), .level_out(level_out)
);

// File: tb/flycap_state_seq_bench.sv
`timescale 1ns/1ps
module flycap_state_seq_bench;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic signed [2:0] level_req = 3'sd0;
  logic              cap_high = 1'b0;
  logic              cur_pos = 1'b0;
  logic [2:0]        sw_state;
  logic signed [2:0] level_out;
  int                total = 0;
  int                bad = 0;
  bit                done = 1'b0;

  always #10 clk = ~clk;

  flycap_state_seq u_flycap_state_seq (
    .clk(clk), .rst_n(rst_n), .level_req(level_req), .cap_high(cap_high),
    .cur_pos(cur_pos), .sw_state(sw_state), .level_out(level_out)
  );

  // {req[2:0], cap_high, cur_pos, expected sw[2:0], expected level[2:0]}
  localparam int NV = 26;
  localparam logic [10:0] VEC [NV] = '{
    {3'b000, 1'b0, 1'b0, 3'b000, 3'b000},  // hold at reset pattern (R3)
    {3'b001, 1'b0, 1'b1, 3'b100, 3'b001},  // pos, cap low -> 100 (R5)
    {3'b010, 1'b0, 1'b0, 3'b110, 3'b010},  // +2 (R8)
    {3'b010, 1'b0, 1'b0, 3'b110, 3'b010},  // hold (R3)
    {3'b001, 1'b1, 1'b1, 3'b010, 3'b001},  // pos, cap high -> 010 (R5)
    {3'b000, 1'b0, 1'b0, 3'b000, 3'b000},  // down into zero via 000 (R8)
    {3'b111, 1'b0, 1'b1, 3'b101, 3'b111},  // 000 -> 101 two-switch (R7, R6)
    {3'b000, 1'b0, 1'b0, 3'b111, 3'b000},  // up into zero via 111 (R8)
    {3'b111, 1'b1, 1'b1, 3'b011, 3'b111},  // 111 -> 011 (R6)
    {3'b110, 1'b0, 1'b0, 3'b001, 3'b110},  // -2 (R8)
    {3'b011, 1'b0, 1'b0, 3'b011, 3'b111},  // +3 saturates, one step (R4)
    {3'b011, 1'b0, 1'b0, 3'b111, 3'b000},
    {3'b011, 1'b1, 1'b0, 3'b100, 3'b001},  // 111 -> 100, neg & cap high (R7, R5)
    {3'b011, 1'b0, 1'b0, 3'b110, 3'b010},
    {3'b100, 1'b0, 1'b0, 3'b010, 3'b001},  // -4 saturates (R4)
    {3'b100, 1'b0, 1'b0, 3'b000, 3'b000},
    {3'b100, 1'b0, 1'b0, 3'b011, 3'b111},  // neg & cap low -> 011 (R6)
    {3'b100, 1'b0, 1'b0, 3'b001, 3'b110},
    {3'b101, 1'b0, 1'b0, 3'b001, 3'b110},  // -3 holds at -2 (R4)
    {3'b001, 1'b1, 1'b0, 3'b101, 3'b111},  // neg & cap high -> 101 (R6)
    {3'b001, 1'b0, 1'b0, 3'b111, 3'b000},
    {3'b001, 1'b0, 1'b0, 3'b010, 3'b001},  // 111 -> 010 (R7)
    {3'b010, 1'b0, 1'b0, 3'b110, 3'b010},
    {3'b001, 1'b1, 1'b0, 3'b100, 3'b001},  // 110 -> 100 (R5)
    {3'b000, 1'b0, 1'b0, 3'b000, 3'b000},
    {3'b001, 1'b0, 1'b0, 3'b010, 3'b001}   // 000 -> 010 (R5)
  };

  task automatic check3(input string tag, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic bit two_switch_ok(input logic [2:0] a, input logic [2:0] b);
    int n;
    n = 0;
    for (int k = 0; k < 3; k++) if (a[k] != b[k]) n++;
    if (n <= 1) return 1'b1;
    if (a == 3'b000 && (b == 3'b101 || b == 3'b011)) return 1'b1;
    if (a == 3'b111 && (b == 3'b100 || b == 3'b010)) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] prev;
    repeat (3) @(posedge clk);
    #2;
    check3("R1 reset pattern", sw_state, 3'b000);
    check3("R1 reset level", level_out, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    prev = sw_state;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      level_req = VEC[i][10:8];
      cap_high  = VEC[i][7];
      cur_pos   = VEC[i][6];
      @(posedge clk);
      #2;
      check3($sformatf("R5/R6/R8 pattern step %0d", i), sw_state, VEC[i][5:3]);
      check3($sformatf("R2/R3 level step %0d", i), level_out, VEC[i][2:0]);
      total++;
      if (!two_switch_ok(prev, sw_state)) begin
        bad++;
        $display("FAIL R7 step %0d actual=%b->%b expected=adjacent", i, prev, sw_state);
      end
      prev = sw_state;
    end
    // R1: asynchronous reset in mid-run from +1 (010)
    @(negedge clk);
    #3;
    rst_n = 1'b0;
    #2;
    check3("R1 async reset pattern", sw_state, 3'b000);
    check3("R1 async reset level", level_out, 3'b000);
    @(negedge clk);
    level_req = 3'sd0;
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check3("R1 idle after reset", sw_state, 3'b000);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule